// File: doc/BRIEF.md
# Secondary Interrupt Bank with Dual Host Lines

This block gathers up to `N_SRC` event inputs from one function of a larger chip and turns chosen transitions on them into latched interrupt status. Each input passes through a two-flop synchronizer. A per-source edge selector then decides whether a rising edge, a falling edge, both or neither counts as an event. Qualified events are latched into status registers and raise an active-low request toward a primary aggregator.

Two host lines are served side by side. Each line owns its own status and mask sets, so two hosts can claim, mask and acknowledge events without disturbing each other. The edge selection is common to both lines. A control register picks how status is acknowledged: either clear-on-read, or write-one-to-clear. A second control bit lets a repeated event that lands on an already-set status bit be held and shown again once the first one has been acknowledged.

Software reaches all registers through a simple synchronous byte port: a write strobe, a read strobe, a byte address, write data and combinational read data. With `S = ceil(N_SRC/8)` and `E = ceil(2*N_SRC/8)`, the map is contiguous and starts at address 0, in this order:
- line-0 status (S bytes)
- line-0 mask (S bytes)
- line-1 status (S bytes)
- line-1 mask (S bytes)
- edge selection (E bytes)
- control (1 byte)

Multi-byte registers keep the least significant byte at the lowest address.

Top module: `sih_bank`

## Requirements
- R1: After reset all status bits are 0, every mask bit reads 1, all edge selection bits and control bits are 0, and both `irq_n_o` bits are 1.
- R2: Source i uses edge selection bits 2i+1 (rising) and 2i (falling), so four sources share each byte. A rising input edge sets status bit i when bit 2i+1 is 1, and a falling edge sets it when bit 2i is 1.
- R3: A source whose two edge selection bits are both 0 never sets a status bit, whatever its input does.
- R4: One qualified event sets the matching status bit in both lines. Clearing or masking in one line leaves the other line's status and request unchanged.
- R5: `irq_n_o[l]` is 0 exactly while some status bit of line l is 1 and its mask bit is 0; a mask bit of 1 blocks that source.
- R6: With control bit 0 set (clear-on-read), a read strobe on a status byte returns its value and clears those bits at the same clock edge. Writes to status bytes have no effect in this mode.
- R7: With control bit 0 clear (write-one-to-clear), a write to a status byte clears exactly the bits written as 1. Reads do not change status.
- R8: With control bit 1 set, an event that arrives while its status bit is already 1 is held. After that bit is cleared, it reads 1 again, and a second clear empties it. With control bit 1 clear, such an event is lost.
- R9: When an event and a clear hit the same status bit in the same cycle, the bit stays 1.
- R10: Status and mask bits at positions N_SRC and above read as 0, edge bits for absent sources read as 0, control bits 7..2 read as 0, and unmapped addresses read as 0.
- R11: An input change applied between clock edges sets its status bit at the third rising edge after the change. The request is not yet active after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N_SRC | Raw event inputs, one per source |
| bus_wr_i | input | 1 | Byte write strobe |
| bus_rd_i | input | 1 | Byte read strobe (used for clear-on-read) |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed byte |
| irq_n_o | output | 2 | Active-low request, one per host line |

## Verification
The bench builds the bank with `N_SRC = 6` and `ADDR_W = 5`. With these values each status and mask set fits in one byte and the edge selection spans two bytes, one full and one half-filled. This makes the whole map only seven bytes long, so every source can be swept through all four edge selections in both input directions. It also places the absent source slots (status bits 7..6, edge bits 15..12) where reads can show that they stay 0. Acknowledgement modes, held repeats, the event-versus-clear collision and the three-edge input latency are each driven with exact cycle placement.

// File: rtl/sih_pkg.sv
package sih_pkg;

    // number of bytes needed to hold a given count of bits
    function automatic int byte_len(input int bits);
        return (bits + 7) / 8;
    endfunction

    localparam int NUM_LINES = 2;

endpackage

// File: rtl/sih_edge_qual.sv
module sih_edge_qual #(
    parameter int N_SRC = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   src_i,
    input  logic [2*N_SRC-1:0] edge_cfg_i,
    output logic [N_SRC-1:0]   evt_o
);

    typedef struct packed {
        logic [N_SRC-1:0] s1;
        logic [N_SRC-1:0] s2;
        logic [N_SRC-1:0] prev;
    } qual_t;

    qual_t qual_d, qual_q;
    logic [N_SRC-1:0] rise_en;
    logic [N_SRC-1:0] fall_en;

    always_comb begin
        qual_d      = qual_q;
        qual_d.s1   = src_i;
        qual_d.s2   = qual_q.s1;
        qual_d.prev = qual_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) qual_q <= '0;
        else        qual_q <= qual_d;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign rise_en[i] = edge_cfg_i[2*i+1];
        assign fall_en[i] = edge_cfg_i[2*i];
        assign evt_o[i] = (qual_q.s2[i] & ~qual_q.prev[i] & rise_en[i])
                        | (~qual_q.s2[i] & qual_q.prev[i] & fall_en[i]);
    end

    // R3
    no_cfg_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & ~(rise_en | fall_en)) == '0));

endmodule

// File: rtl/sih_line_bank.sv
module sih_line_bank #(
    parameter int N_SRC = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic             buf_en_i,
    input  logic [N_SRC-1:0] clr_i,
    input  logic [N_SRC-1:0] mk_we_i,
    input  logic [N_SRC-1:0] mk_wval_i,
    output logic [N_SRC-1:0] st_o,
    output logic [N_SRC-1:0] mk_o,
    output logic             req_n_o
);

    typedef struct packed {
        logic [N_SRC-1:0] st;
        logic [N_SRC-1:0] pend;
        logic [N_SRC-1:0] mk;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [N_SRC-1:0] pend_use;

    always_comb begin
        bank_d   = bank_q;
        // a held repeat moves into status when its bit is cleared
        pend_use = clr_i & bank_q.st & bank_q.pend;
        // new event wins over a clear of the same bit
        bank_d.st = (bank_q.st & ~clr_i) | evt_i | pend_use;
        if (buf_en_i)
            bank_d.pend = (bank_q.pend & ~pend_use)
                        | (evt_i & bank_q.st & (~clr_i | bank_q.pend));
        else
            bank_d.pend = '0;
        bank_d.mk = (bank_q.mk & ~mk_we_i) | (mk_wval_i & mk_we_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.st   <= '0;
            bank_q.pend <= '0;
            bank_q.mk   <= '1;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign st_o    = bank_q.st;
    assign mk_o    = bank_q.mk;
    assign req_n_o = ~|(bank_q.st & ~bank_q.mk);

    // R9
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((bank_q.st & $past(evt_i)) == $past(evt_i)));

    // R7
    clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~evt_i & ~bank_q.pend)) |=>
        ((bank_q.st & $past(clr_i & ~evt_i & ~bank_q.pend)) == '0));

    // R8
    nobuf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_en_i) |=> (bank_q.pend == '0));

endmodule

// File: rtl/sih_bank.sv
module sih_bank #(
    parameter int N_SRC  = 18,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    output logic [1:0]        irq_n_o
);

    localparam int NL    = sih_pkg::NUM_LINES;
    localparam int STB   = sih_pkg::byte_len(N_SRC);
    localparam int EB    = sih_pkg::byte_len(2 * N_SRC);
    localparam int A_EDG = 2 * NL * STB;
    localparam int A_CTL = A_EDG + EB;

    typedef struct packed {
        logic [2*N_SRC-1:0] edg;
        logic               buf_en;
        logic               cor;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [N_SRC-1:0] evt;
    logic [N_SRC-1:0] mk_val;
    logic [N_SRC-1:0] clr_a  [NL];
    logic [N_SRC-1:0] mkwe_a [NL];
    logic [N_SRC-1:0] st_a   [NL];
    logic [N_SRC-1:0] mk_a   [NL];

    // configuration registers
    always_comb begin
        cfg_d = cfg_q;
        for (int j = 0; j < 2 * N_SRC; j++) begin
            if (bus_wr_i && bus_addr_i == ADDR_W'(A_EDG + j / 8))
                cfg_d.edg[j] = bus_wdata_i[j % 8];
        end
        if (bus_wr_i && bus_addr_i == ADDR_W'(A_CTL)) begin
            cfg_d.cor    = bus_wdata_i[0];
            cfg_d.buf_en = bus_wdata_i[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // per-line clear and mask-write decode
    always_comb begin
        for (int l = 0; l < NL; l++) begin
            for (int i = 0; i < N_SRC; i++) begin
                if (cfg_q.cor)
                    clr_a[l][i] = bus_rd_i &&
                        bus_addr_i == ADDR_W'(2 * l * STB + i / 8);
                else
                    clr_a[l][i] = bus_wr_i && bus_wdata_i[i % 8] &&
                        bus_addr_i == ADDR_W'(2 * l * STB + i / 8);
                mkwe_a[l][i] = bus_wr_i &&
                    bus_addr_i == ADDR_W'((2 * l + 1) * STB + i / 8);
            end
        end
        for (int i = 0; i < N_SRC; i++) mk_val[i] = bus_wdata_i[i % 8];
    end

    sih_edge_qual #(.N_SRC(N_SRC)) i_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .edge_cfg_i (cfg_q.edg),
        .evt_o      (evt)
    );

    for (genvar l = 0; l < NL; l++) begin : g_line
        sih_line_bank #(.N_SRC(N_SRC)) i_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt),
            .buf_en_i  (cfg_q.buf_en),
            .clr_i     (clr_a[l]),
            .mk_we_i   (mkwe_a[l]),
            .mk_wval_i (mk_val),
            .st_o      (st_a[l]),
            .mk_o      (mk_a[l]),
            .req_n_o   (irq_n_o[l])
        );

        // R5
        masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (&mk_a[l]) |-> irq_n_o[l]);
    end

    // read mux: absent bit positions fall through as zero
    always_comb begin
        bus_rdata_o = '0;
        for (int l = 0; l < NL; l++) begin
            for (int i = 0; i < N_SRC; i++) begin
                if (bus_addr_i == ADDR_W'(2 * l * STB + i / 8))
                    bus_rdata_o[i % 8] = st_a[l][i];
                if (bus_addr_i == ADDR_W'((2 * l + 1) * STB + i / 8))
                    bus_rdata_o[i % 8] = mk_a[l][i];
            end
        end
        for (int j = 0; j < 2 * N_SRC; j++) begin
            if (bus_addr_i == ADDR_W'(A_EDG + j / 8))
                bus_rdata_o[j % 8] = cfg_q.edg[j];
        end
        if (bus_addr_i == ADDR_W'(A_CTL)) begin
            bus_rdata_o[0] = cfg_q.cor;
            bus_rdata_o[1] = cfg_q.buf_en;
        end
    end

endmodule

// File: tb/test_sih_bank.sv
`timescale 1ns/1ps
module test_sih_bank;

    localparam int N  = 6;
    localparam int AW = 5;
    // map for N = 6: one byte per status/mask set, two edge bytes
    localparam logic [AW-1:0] ST0 = 0, MK0 = 1, ST1 = 2, MK1 = 3,
                              ED0 = 4, ED1 = 5, CTL = 6, NOMAP = 7;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [N-1:0]  src = '0;
    logic          wr = 0, rd = 0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic [1:0]    irq_n;
    int            total = 0, bad = 0;
    bit            done = 0;

    sih_bank #(.N_SRC(N), .ADDR_W(AW)) i_sih_bank (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_n_o(irq_n)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    // all bus tasks start and end just after a falling edge
    task automatic do_wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr = 1; addr = a; wdata = d;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic do_rd(input logic [AW-1:0] a, output logic [7:0] d);
        rd = 1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
        logic [7:0] d;
        do_rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=hung exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 st0", ST0, 8'h00);
        rd_chk("R1 mk0", MK0, 8'h3F);
        rd_chk("R1 st1", ST1, 8'h00);
        rd_chk("R1 mk1", MK1, 8'h3F);
        rd_chk("R1 ed0", ED0, 8'h00);
        rd_chk("R1 ed1", ED1, 8'h00);
        rd_chk("R1 ctl", CTL, 8'h00);
        check("R1 irq", {6'd0, irq_n}, 8'h03);
        rd_chk("R10 unmapped", NOMAP, 8'h00);

        // R2/R3/R4 sweep: every source, every edge selection, both directions
        for (int i = 0; i < N; i++) begin
            for (int c = 0; c < 4; c++) begin
                logic [7:0] pair;
                logic [7:0] bitv;
                string tg;
                pair = 8'(c) << ((i % 4) * 2);
                bitv = 8'(1) << i;
                tg = (c == 0) ? "R3" : "R2";
                do_wr(ED0, (i < 4) ? pair : 8'h00);
                do_wr(ED1, (i < 4) ? 8'h00 : pair);
                do_wr(ST0, 8'hFF);
                do_wr(ST1, 8'hFF);
                src[i] = 1'b1;
                settle();
                rd_chk({tg, " rise line0"}, ST0, c[1] ? bitv : 8'h00);
                rd_chk({"R4 rise line1"}, ST1, c[1] ? bitv : 8'h00);
                do_wr(ST0, 8'hFF);
                do_wr(ST1, 8'hFF);
                src[i] = 1'b0;
                settle();
                rd_chk({tg, " fall line0"}, ST0, c[0] ? bitv : 8'h00);
                rd_chk({"R4 fall line1"}, ST1, c[0] ? bitv : 8'h00);
            end
        end
        check("R3 masked irq", {6'd0, irq_n}, 8'h03);
        do_wr(ED1, 8'h00);
        do_wr(ST0, 8'hFF);
        do_wr(ST1, 8'hFF);

        // R11 latency and R5 request
        do_wr(ED0, 8'h02);
        do_wr(MK0, 8'h01 ^ 8'h3F);
        src[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R11 not yet", {6'd0, irq_n}, 8'h03);
        @(negedge clk);
        check("R11 set at third edge", {6'd0, irq_n}, 8'h02);
        do_wr(MK0, 8'h3F);
        check("R5 masked line0", {6'd0, irq_n}, 8'h03);
        do_wr(MK1, 8'h00);
        check("R5 unmasked line1", {6'd0, irq_n}, 8'h01);
        do_wr(ST1, 8'h01);
        check("R4 clear line1 only", {6'd0, irq_n}, 8'h03);
        rd_chk("R4 line0 kept", ST0, 8'h01);
        do_wr(MK1, 8'h3F);
        do_wr(ST0, 8'hFF);
        src[0] = 1'b0;
        settle();

        // R6 clear-on-read
        do_wr(ED0, 8'h0C);
        do_wr(CTL, 8'h01);
        src[1] = 1'b1;
        settle();
        do_wr(ST0, 8'hFF);
        rd_chk("R6 write ignored, read", ST0, 8'h02);
        rd_chk("R6 cleared by read", ST0, 8'h00);
        rd_chk("R6 other line kept", ST1, 8'h02);
        rd_chk("R6 other line cleared", ST1, 8'h00);
        src[1] = 1'b0;
        settle();
        rd_chk("R6 fall read", ST0, 8'h02);
        rd_chk("R6 fall read line1", ST1, 8'h02);

        // R7 write-one-to-clear
        do_wr(CTL, 8'h00);
        src[1] = 1'b1;
        settle();
        rd_chk("R7 read", ST0, 8'h02);
        rd_chk("R7 read keeps", ST0, 8'h02);
        do_wr(ST0, 8'hFD);
        rd_chk("R7 zeros keep", ST0, 8'h02);
        do_wr(ST0, 8'h02);
        rd_chk("R7 one clears", ST0, 8'h00);
        src[1] = 1'b0;
        settle();
        do_wr(ST0, 8'hFF);
        do_wr(ST1, 8'hFF);

        // R8 held repeat
        do_wr(ED0, 8'h03);
        do_wr(CTL, 8'h02);
        src[0] = 1'b1;
        settle();
        src[0] = 1'b0;
        settle();
        do_wr(ST0, 8'h01);
        rd_chk("R8 repeat reappears", ST0, 8'h01);
        do_wr(ST0, 8'h01);
        rd_chk("R8 second clear", ST0, 8'h00);
        do_wr(CTL, 8'h00);
        do_wr(ST1, 8'hFF);
        src[0] = 1'b1;
        settle();
        src[0] = 1'b0;
        settle();
        do_wr(ST0, 8'h01);
        rd_chk("R8 no hold when off", ST0, 8'h00);

        // R9 event and clear in the same cycle
        src[0] = 1'b1;
        settle();
        src[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        do_wr(ST0, 8'h01);
        rd_chk("R9 event wins", ST0, 8'h01);
        do_wr(ST0, 8'h01);
        rd_chk("R9 later clear", ST0, 8'h00);
        do_wr(ST1, 8'hFF);

        // R10 absent positions
        do_wr(ED0, 8'hAA);
        do_wr(ED1, 8'hFF);
        rd_chk("R10 edge pad", ED1, 8'h0F);
        do_wr(ED1, 8'h0A);
        src = '1;
        settle();
        rd_chk("R10 status pad", ST0, 8'h3F);
        do_wr(MK0, 8'hFF);
        rd_chk("R10 mask pad", MK0, 8'h3F);
        do_wr(CTL, 8'hFF);
        rd_chk("R10 ctl pad", CTL, 8'h03);
        do_wr(CTL, 8'h00);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule